// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver with End-of-Interrupt Control

This block sits between eight peripheral interrupt lines and a processor's single interrupt input. It records which lines are requesting service, applies a per-line mask, tracks which levels are being serviced, and raises its interrupt output only when an unmasked request outranks everything already in service. The acknowledge controls from the bus side move the winning level from the request register into the in-service register. End-of-interrupt commands, arriving as a strobe with a decoded operation code and a level field, retire in-service levels.

Priority is a ring. One level is named the lowest, and the level after it (modulo the level count) is the highest. The lowest level can be set directly or moved as a side effect of retiring a level, which gives round-robin service among equal-importance sources. Two optional behaviours sit on top of the ring. Special mask mode lets any level that is not in service interrupt. A poll interface lets software read the winning level directly and acknowledge it.

Top module: `irq_ring_arbiter`

## Requirements
- R1: After reset the request, in-service and mask registers read 0, the lowest-priority level reads 7 (so level 0 ranks highest), automatic rotation is off, and `irq_o` is low.
- R2: With `level_mode_i` low, a 0-to-1 transition on `req_i[n]` sets request bit n. The bit stays set after the input falls, until level n is acknowledged.
- R3: With `level_mode_i` high, request bit n takes the value of `req_i[n]` on every clock, except in the cycle where level n is acknowledged.
- R4: A mask bit of 1 removes its level from arbitration, and a mask bit of 0 restores it. The request bit is still recorded while the level is masked. `mask_we_i` loads `mask_i` into the mask register.
- R5: Outside special mask mode, a request wins only if its rank is strictly higher than the rank of every in-service level, so equal or lower requests are held off. The rank of level n is (n - lowest - 1) mod 8, where 0 is the highest.
- R6: `ack_set_i` (or a poll read) while a winner exists sets the in-service bit of `win_lvl_o` and clears its request bit. With no winner it changes nothing.
- R7: Operation code 1 (non-specific EOI) clears the highest-ranked in-service bit. With the default ring and levels 4 and 6 in service, bit 4 is cleared.
- R8: Operation code 2 (specific EOI) clears the in-service bit named by `cmd_lvl_i`.
- R9: Operation code 3 (rotating non-specific EOI) clears the highest-ranked in-service bit and makes that level the lowest priority. Retiring level 4 this way makes level 5 the highest.
- R10: Operation code 4 (rotating specific EOI) clears bit `cmd_lvl_i` and makes it the lowest. Operation code 5 (set priority) makes `cmd_lvl_i` the lowest and leaves the in-service register untouched.
- R11: Operation code 6 turns automatic rotation on and code 7 turns it off. While it is on, `ack_clr_i` performs a rotating non-specific EOI. While it is off, `ack_clr_i` has no effect.
- R12: While `special_mask_i` is high, any unmasked requesting level that is not in service may win, whatever its rank relative to the in-service levels.
- R13: `poll_word_o` holds bit 7 = winner present and bits 2:0 = winning level (all zero when there is no winner). `irq_o` stays low while `poll_mode_i` is high. A `poll_rd_i` strobe acknowledges the level it reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Interrupt request lines |
| level_mode_i | input | 1 | 1 = level-sensitive, 0 = rising-edge capture |
| mask_we_i | input | 1 | Load the mask register |
| mask_i | input | 8 | New mask value (1 = masked) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command operation code (see R7 to R11) |
| cmd_lvl_i | input | 3 | Level operand for specific and priority commands |
| special_mask_i | input | 1 | Special mask mode enable |
| poll_mode_i | input | 1 | Poll mode; suppresses `irq_o` |
| poll_rd_i | input | 1 | Poll read strobe (acts as acknowledge) |
| ack_set_i | input | 1 | First acknowledge: latch winner into service |
| ack_clr_i | input | 1 | Final acknowledge: automatic rotating EOI when enabled |
| irq_o | output | 1 | Interrupt to processor |
| win_lvl_o | output | 3 | Winning level (0 when none) |
| poll_word_o | output | 8 | Poll status word |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |
| low_lvl_o | output | 3 | Current lowest-priority level |

## Verification
The bench goes after four corner cases. The first is a request of lower rank than a level already in service: a resolver that compares against the request register alone would raise `irq_o` there. The second is the non-specific EOI after the ring has been rotated: a design that picks by fixed index would clear the wrong bit. The third is an edge-mode request whose input has already dropped, which a design that follows the input level would lose. The fourth is `ack_clr_i` with automatic rotation switched off, which a design must ignore rather than retire a level. Special mask mode and poll mode are toggled while requests are held in service, so that a wrong suppression or eligibility rule shows up as a wrong winner or a stray interrupt.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

   // Command operation codes carried on cmd_op_i
   typedef enum logic [2:0] {
      OP_NOP         = 3'd0,
      OP_EOI_NS      = 3'd1,
      OP_EOI_SP      = 3'd2,
      OP_ROT_NS      = 3'd3,
      OP_ROT_SP      = 3'd4,
      OP_SET_PRI     = 3'd5,
      OP_AUTOROT_ON  = 3'd6,
      OP_AUTOROT_OFF = 3'd7
   } eoi_op_e;

   localparam int unsigned POLL_W = 8;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
   parameter int unsigned NUM_LVL = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               level_mode_i,
   input  logic [NUM_LVL-1:0] req_i,
   input  logic [NUM_LVL-1:0] clr_i,
   output logic [NUM_LVL-1:0] irr_o
);

   logic [NUM_LVL-1:0] req_q;
   logic [NUM_LVL-1:0] irr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= '0;
      else         req_q <= req_i;
   end

   for (genvar b = 0; b < NUM_LVL; b++) begin : g_bit
      logic hit;

      // level capture follows the pin; edge capture holds until acknowledged
      assign hit = level_mode_i ? req_i[b] : (irr_q[b] | (req_i[b] & ~req_q[b]));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irr_q[b] <= 1'b0;
         else         irr_q[b] <= hit & ~clr_i[b];
      end

      assert_edge_hold_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!level_mode_i && irr_q[b] && !clr_i[b]) |=> irr_q[b]);

      assert_level_follow_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (level_mode_i && !clr_i[b]) |=> (irr_q[b] == $past(req_i[b])));
   end

   assign irr_o = irr_q;

endmodule

// File: rtl/irq_ring_pick.sv
module irq_ring_pick #(
   parameter  int unsigned NUM_LVL = 8,
   localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] vec_i,
   input  logic [LVL_W-1:0]   low_i,
   output logic               found_o,
   output logic [LVL_W-1:0]   lvl_o,
   output logic [LVL_W-1:0]   rank_o
);

   // rot[k] is the level of rank k; rank 0 sits just after the lowest level
   logic [NUM_LVL-1:0] rot;

   for (genvar k = 0; k < NUM_LVL; k++) begin : g_rot
      localparam logic [LVL_W-1:0] OFS = LVL_W'(k + 1);
      logic [LVL_W-1:0] src;
      assign src    = low_i + OFS;
      assign rot[k] = vec_i[src];
   end

   always_comb begin
      rank_o  = '0;
      found_o = 1'b0;
      for (int k = NUM_LVL - 1; k >= 0; k--) begin
         if (rot[k]) begin
            rank_o  = LVL_W'(k);
            found_o = 1'b1;
         end
      end
   end

   assign lvl_o = low_i + rank_o + LVL_W'(1);

endmodule

// File: rtl/irq_eoi_ctl.sv
module irq_eoi_ctl
   import irq_ring_pkg::*;
#(
   parameter  int unsigned NUM_LVL = 8,
   localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [LVL_W-1:0]   cmd_lvl_i,
   input  logic [NUM_LVL-1:0] set_i,
   input  logic               ack_clr_i,
   input  logic               top_found_i,
   input  logic [LVL_W-1:0]   top_lvl_i,
   output logic [NUM_LVL-1:0] isr_o,
   output logic [LVL_W-1:0]   low_o
);

   eoi_op_e            op;
   logic [NUM_LVL-1:0] isr_q, clr, top_oh, lvl_oh;
   logic [LVL_W-1:0]   low_q, low_d;
   logic               autorot_q, auto_fire;

   assign op        = eoi_op_e'(cmd_op_i);
   assign top_oh    = top_found_i ? (NUM_LVL'(1) << top_lvl_i) : '0;
   assign lvl_oh    = NUM_LVL'(1) << cmd_lvl_i;
   assign auto_fire = ack_clr_i && autorot_q && top_found_i;

   // automatic retirement first; an explicit command overrides the ring update
   always_comb begin
      clr   = auto_fire ? top_oh : '0;
      low_d = auto_fire ? top_lvl_i : low_q;
      if (cmd_valid_i) begin
         case (op)
            OP_EOI_NS:  clr = clr | top_oh;
            OP_EOI_SP:  clr = clr | lvl_oh;
            OP_ROT_NS: begin
               clr = clr | top_oh;
               if (top_found_i) low_d = top_lvl_i;
            end
            OP_ROT_SP: begin
               clr   = clr | lvl_oh;
               low_d = cmd_lvl_i;
            end
            OP_SET_PRI: low_d = cmd_lvl_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         isr_q     <= '0;
         low_q     <= LVL_W'(NUM_LVL - 1);
         autorot_q <= 1'b0;
      end else begin
         isr_q <= (isr_q & ~clr) | set_i;
         low_q <= low_d;
         if (cmd_valid_i && op == OP_AUTOROT_ON)  autorot_q <= 1'b1;
         if (cmd_valid_i && op == OP_AUTOROT_OFF) autorot_q <= 1'b0;
      end
   end

   assign isr_o = isr_q;
   assign low_o = low_q;

   assert_spec_eoi_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && op == OP_EOI_SP && set_i == '0) |=> ((isr_q & $past(lvl_oh)) == '0));

   assert_rot_ns_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && op == OP_ROT_NS && top_found_i) |=> (low_q == $past(top_lvl_i)));

   assert_set_low_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && (op == OP_SET_PRI || op == OP_ROT_SP)) |=> (low_q == $past(cmd_lvl_i)));

   assert_setpri_keeps_isr_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && op == OP_SET_PRI && set_i == '0 && !ack_clr_i) |=> (isr_q == $past(isr_q)));

   assert_autorot_R11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (autorot_q && ack_clr_i && top_found_i && !cmd_valid_i) |=> (low_q == $past(top_lvl_i)));

endmodule

// File: rtl/irq_ring_arbiter.sv
module irq_ring_arbiter
   import irq_ring_pkg::*;
#(
   parameter  int unsigned NUM_LVL = 8,
   localparam int unsigned LVL_W   = $clog2(NUM_LVL)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_LVL-1:0] req_i,
   input  logic               level_mode_i,
   input  logic               mask_we_i,
   input  logic [NUM_LVL-1:0] mask_i,
   input  logic               cmd_valid_i,
   input  logic [2:0]         cmd_op_i,
   input  logic [LVL_W-1:0]   cmd_lvl_i,
   input  logic               special_mask_i,
   input  logic               poll_mode_i,
   input  logic               poll_rd_i,
   input  logic               ack_set_i,
   input  logic               ack_clr_i,
   output logic               irq_o,
   output logic [LVL_W-1:0]   win_lvl_o,
   output logic [POLL_W-1:0]  poll_word_o,
   output logic [NUM_LVL-1:0] irr_o,
   output logic [NUM_LVL-1:0] isr_o,
   output logic [NUM_LVL-1:0] imr_o,
   output logic [LVL_W-1:0]   low_lvl_o
);

   if (NUM_LVL < 2 || (NUM_LVL & (NUM_LVL - 1)) != 0 || LVL_W >= POLL_W) begin : g_bad_cfg
      $error("irq_ring_arbiter: NUM_LVL must be a power of two between 2 and 128");
   end

   logic [NUM_LVL-1:0] imr_q, cand, set_oh, win_oh;
   logic               c_found, s_found, grant_ok, take;
   logic [LVL_W-1:0]   c_lvl, c_rank, s_lvl, s_rank;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        imr_q <= '0;
      else if (mask_we_i) imr_q <= mask_i;
   end

   irq_req_latch #(.NUM_LVL(NUM_LVL)) u_req (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .level_mode_i (level_mode_i),
      .req_i        (req_i),
      .clr_i        (set_oh),
      .irr_o        (irr_o)
   );

   // special mask mode drops in-service levels from the candidate set instead of ranking against them
   assign cand = special_mask_i ? (irr_o & ~imr_q & ~isr_o) : (irr_o & ~imr_q);

   irq_ring_pick #(.NUM_LVL(NUM_LVL)) u_pick_req (
      .vec_i   (cand),
      .low_i   (low_lvl_o),
      .found_o (c_found),
      .lvl_o   (c_lvl),
      .rank_o  (c_rank)
   );

   irq_ring_pick #(.NUM_LVL(NUM_LVL)) u_pick_isr (
      .vec_i   (isr_o),
      .low_i   (low_lvl_o),
      .found_o (s_found),
      .lvl_o   (s_lvl),
      .rank_o  (s_rank)
   );

   assign grant_ok  = c_found && (special_mask_i || !s_found || (c_rank < s_rank));
   assign take      = (ack_set_i || poll_rd_i) && grant_ok;
   assign set_oh    = take ? (NUM_LVL'(1) << c_lvl) : '0;
   assign irq_o     = grant_ok && !poll_mode_i;
   assign win_lvl_o = grant_ok ? c_lvl : '0;
   assign win_oh    = NUM_LVL'(1) << win_lvl_o;
   assign imr_o     = imr_q;

   always_comb begin
      poll_word_o = '0;
      poll_word_o[POLL_W-1] = grant_ok;
      if (grant_ok) poll_word_o[LVL_W-1:0] = c_lvl;
   end

   irq_eoi_ctl #(.NUM_LVL(NUM_LVL)) u_eoi (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_valid_i (cmd_valid_i),
      .cmd_op_i    (cmd_op_i),
      .cmd_lvl_i   (cmd_lvl_i),
      .set_i       (set_oh),
      .ack_clr_i   (ack_clr_i),
      .top_found_i (s_found),
      .top_lvl_i   (s_lvl),
      .isr_o       (isr_o),
      .low_o       (low_lvl_o)
   );

   assert_irq_unmasked_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (((win_oh & imr_q) == '0) && ((win_oh & irr_o) != '0)));

   assert_irq_not_in_service_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ((win_oh & isr_o) == '0));

   assert_ack_sets_isr_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take && !cmd_valid_i && !ack_clr_i) |=> ((isr_o & $past(set_oh)) != '0));

   assert_ack_clears_irr_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      take |=> ((irr_o & $past(set_oh)) == '0));

   assert_poll_reports_request_R13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      poll_word_o[POLL_W-1] |-> ((irr_o & win_oh) != '0));

endmodule

// File: tb/tb_irq_ring_arbiter.sv
module tb_irq_ring_arbiter;
   localparam int N = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n;
   logic [7:0] req, mask_d;
   logic       lvl_mode, mask_we, cmd_v, smm, pmode, prd, aset, aclr;
   logic [2:0] cmd_op, cmd_lvl;
   logic       irq;
   logic [2:0] win, low;
   logic [7:0] pw, irr, isr, imr;

   irq_ring_arbiter dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .level_mode_i(lvl_mode),
      .mask_we_i(mask_we), .mask_i(mask_d), .cmd_valid_i(cmd_v), .cmd_op_i(cmd_op),
      .cmd_lvl_i(cmd_lvl), .special_mask_i(smm), .poll_mode_i(pmode), .poll_rd_i(prd),
      .ack_set_i(aset), .ack_clr_i(aclr), .irq_o(irq), .win_lvl_o(win),
      .poll_word_o(pw), .irr_o(irr), .isr_o(isr), .imr_o(imr), .low_lvl_o(low)
   );

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit [7:0] m_irr, m_isr, m_imr, m_reqq;
   int       m_low;
   bit       m_auto;

   function automatic int top_of(bit [7:0] v, int lo);
      for (int k = 1; k <= N; k++) if (v[(lo + k) % N]) return (lo + k) % N;
      return -1;
   endfunction

   function automatic int rank_of(int l, int lo);
      return (l - lo - 1 + 2 * N) % N;
   endfunction

   function automatic int model_win();
      bit [7:0] c;
      int w, t;
      c = smm ? (m_irr & ~m_imr & ~m_isr) : (m_irr & ~m_imr);
      w = top_of(c, m_low);
      if (w < 0) return -1;
      if (smm) return w;
      t = top_of(m_isr, m_low);
      if (t >= 0 && rank_of(w, m_low) >= rank_of(t, m_low)) return -1;
      return w;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_irr = 0; m_isr = 0; m_imr = 0; m_reqq = 0; m_low = N - 1; m_auto = 0;
      end else begin
         int w, t, nlow;
         bit [7:0] setm, clrm;
         bit nauto;
         w = model_win();
         t = top_of(m_isr, m_low);
         setm = ((aset || prd) && w >= 0) ? 8'(1 << w) : 8'h00;
         clrm = 0; nlow = m_low; nauto = m_auto;
         if (aclr && m_auto && t >= 0) begin clrm |= 8'(1 << t); nlow = t; end
         if (cmd_v) begin
            case (cmd_op)
               3'd1: if (t >= 0) clrm |= 8'(1 << t);
               3'd2: clrm |= 8'(1 << cmd_lvl);
               3'd3: if (t >= 0) begin clrm |= 8'(1 << t); nlow = t; end
               3'd4: begin clrm |= 8'(1 << cmd_lvl); nlow = cmd_lvl; end
               3'd5: nlow = cmd_lvl;
               3'd6: nauto = 1;
               3'd7: nauto = 0;
               default: ;
            endcase
         end
         if (lvl_mode) m_irr = req & ~setm;
         else          m_irr = (m_irr | (req & ~m_reqq)) & ~setm;
         m_isr  = (m_isr & ~clrm) | setm;
         if (mask_we) m_imr = mask_d;
         m_reqq = req;
         m_low  = nlow;
         m_auto = nauto;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int w;
         w = model_win();
         chk(irr, m_irr, "R2 request register");
         chk(isr, m_isr, "R6 in-service register");
         chk(imr, m_imr, "R4 mask register");
         chk(low, m_low, "R9 lowest level");
         chk(irq, (w >= 0 && !pmode), "R5 interrupt output");
         chk(win, (w >= 0) ? w : 0, "R6 winning level");
         chk(pw, (w >= 0) ? (32'h80 | w) : 0, "R13 poll word");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic edge_();
      @(posedge clk); #1;
   endtask
   task automatic set_req(input logic [7:0] v);
      edge_(); req = v; edge_();
   endtask
   task automatic do_cmd(input int op, input int l);
      edge_(); cmd_v = 1; cmd_op = 3'(op); cmd_lvl = 3'(l); edge_(); cmd_v = 0;
   endtask
   task automatic do_ack();
      edge_(); aset = 1; edge_(); aset = 0;
   endtask
   task automatic do_aclr();
      edge_(); aclr = 1; edge_(); aclr = 0;
   endtask
   task automatic do_poll();
      edge_(); prd = 1; edge_(); prd = 0;
   endtask
   task automatic do_mask(input logic [7:0] v);
      edge_(); mask_we = 1; mask_d = v; edge_(); mask_we = 0;
   endtask

   initial begin
      rst_n = 0; req = 0; mask_d = 0; lvl_mode = 0; mask_we = 0; cmd_v = 0;
      cmd_op = 0; cmd_lvl = 0; smm = 0; pmode = 0; prd = 0; aset = 0; aclr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irr, 0, "R1 irr"); chk(isr, 0, "R1 isr"); chk(imr, 0, "R1 imr");
      chk(low, 7, "R1 lowest"); chk(irq, 0, "R1 irq");

      set_req(8'h50); @(negedge clk);
      chk(irr, 8'h50, "R2 edge capture"); chk(irq, 1, "R5 irq"); chk(win, 4, "R5 winner");
      set_req(8'h00); @(negedge clk);
      chk(irr, 8'h50, "R2 held after input drop");
      do_ack(); @(negedge clk);
      chk(isr, 8'h10, "R6 isr set"); chk(irr, 8'h40, "R6 irr cleared");
      chk(irq, 0, "R5 lower rank held off");
      edge_(); smm = 1; @(negedge clk);
      chk(irq, 1, "R12 special mask irq"); chk(win, 6, "R12 winner");
      do_ack(); @(negedge clk);
      chk(isr, 8'h50, "R12 nested below service");
      edge_(); smm = 0;
      do_cmd(1, 0); @(negedge clk);
      chk(isr, 8'h40, "R7 non-specific EOI clears level 4");
      do_cmd(2, 6); @(negedge clk);
      chk(isr, 8'h00, "R8 specific EOI");

      do_mask(8'h08); set_req(8'h08); @(negedge clk);
      chk(irr, 8'h08, "R4 masked still recorded"); chk(irq, 0, "R4 masked no irq");
      do_mask(8'h00); @(negedge clk);
      chk(irq, 1, "R4 unmasked irq"); chk(win, 3, "R4 winner");
      do_ack(); do_cmd(3, 0); @(negedge clk);
      chk(isr, 8'h00, "R9 rotate clears"); chk(low, 3, "R9 lowest");
      set_req(8'h21); @(negedge clk);
      chk(win, 5, "R9 rotated winner");

      do_cmd(5, 5); @(negedge clk);
      chk(low, 5, "R10 set priority"); chk(isr, 0, "R10 isr kept"); chk(win, 0, "R10 winner");
      do_ack(); @(negedge clk);
      chk(isr, 8'h01, "R6 ack level 0");
      do_cmd(4, 0); @(negedge clk);
      chk(isr, 8'h00, "R10 rotate specific"); chk(low, 0, "R10 lowest"); chk(win, 5, "R10 winner");

      do_cmd(6, 0); do_ack(); @(negedge clk);
      chk(isr, 8'h20, "R11 ack with auto rotate");
      do_aclr(); @(negedge clk);
      chk(isr, 8'h00, "R11 auto rotate clears"); chk(low, 5, "R11 lowest");
      do_cmd(7, 0); set_req(8'h23); @(negedge clk);
      chk(win, 1, "R11 winner");
      do_ack(); do_aclr(); @(negedge clk);
      chk(isr, 8'h02, "R11 ack_clr ignored when off"); chk(low, 5, "R11 lowest kept");
      do_cmd(1, 0);

      edge_(); lvl_mode = 1; req = 8'h81; edge_(); @(negedge clk);
      chk(irr, 8'h81, "R3 level follow");
      set_req(8'h01); @(negedge clk);
      chk(irr, 8'h01, "R3 level drop");
      set_req(8'h00); @(negedge clk);
      chk(irr, 8'h00, "R3 level clear");

      edge_(); lvl_mode = 0; pmode = 1;
      set_req(8'h80); @(negedge clk);
      chk(irq, 0, "R13 irq suppressed"); chk(pw, 8'h87, "R13 poll word");
      do_poll(); @(negedge clk);
      chk(isr, 8'h80, "R13 poll acknowledges"); chk(irr, 8'h00, "R13 irr cleared");
      chk(pw, 8'h00, "R13 empty poll word");
      do_cmd(2, 7);
      edge_(); pmode = 0; req = 0;
      @(negedge clk);
      chk(isr, 8'h00, "R8 final clear");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule